// File: doc/BRIEF.md
# DES Round-Key Sequencer

This block turns a 64-bit DES key into the sixteen 48-bit round keys, one key per step. A one-cycle load strobe captures the key. The block drops the eight parity bits and scatters the remaining 56 bits into two 28-bit halves. It then presents the first round key at once. Each advance strobe moves to the next round key: both halves rotate by the amount that belongs to that round, and a fixed wiring selection of 48 bits forms the key. The only storage is the 56-bit pair of halves and a small step counter.

A mode input is sampled at load time and selects the direction of the sequence. In the forward direction the keys come out in cipher order, from round 1 to round 16. In the reverse direction the halves rotate right, so the keys come out from round 16 down to round 1, which is the order a decryption data path needs. The sixteen keys are never stored. The valid flag covers exactly sixteen keys and then drops until the next load.

Top module: `des_key_sequencer`

## Requirements
- R1: While reset is low and after it is released, key_valid is 0, round_idx is 0 and round_key is all zeros.
- R2: One cycle after a load with decrypt low, key_valid is 1, round_idx is 0 and round_key holds the round-1 key. key_in[63] is key bit 1 and round_key[47] is subkey bit 1.
- R3: Before each round, both halves rotate left by one bit for rounds 1, 2, 9 and 16, and by two bits for all other rounds. For key 0x133457799BBCDFF1 the sixteen keys match the published schedule.
- R4: Each advance while valid presents the next key of the sequence one cycle later. In the forward direction round_idx goes up by one.
- R5: One cycle after a load with decrypt high, round_key holds the round-16 key with round_idx 15. Each later advance gives the key of the preceding round, and round_idx goes down by one.
- R6: key_valid stays 1 for exactly sixteen keys. The advance that arrives while the sixteenth key is shown clears key_valid.
- R7: An advance while key_valid is 0 has no effect: round_key and round_idx stay the same, and key_valid stays 0.
- R8: A load takes priority over an advance in the same cycle and restarts the sequence from its first key, even partway through a sequence.
- R9: While advance and load are both low, round_key, round_idx and key_valid hold their values.
- R10: The direction is fixed when the load happens. Changing decrypt in the middle of a sequence does not change the order.
- R11: The parity bits key_in[0], key_in[8], ..., key_in[56] have no effect on any round key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture key_in and mode, restart the sequence |
| key_in | input | 64 | DES key, bit 63 is key bit 1 |
| decrypt | input | 1 | Reverse-order mode, sampled at load |
| advance | input | 1 | Step to the next round key |
| round_key | output | 48 | Current round key, bit 47 is subkey bit 1 |
| round_idx | output | 4 | Round number of the shown key minus one |
| key_valid | output | 1 | round_key is one of the sixteen keys of the current sequence |

## Verification
The bench walks the standard test key in both directions and compares every key, so a single wrong shift amount shows up as a mismatch. If the schedule is off at round 9 or round 16, every key from that round on is wrong. In the reverse direction, an extra rotation before the first key gives a wrong round-16 key. Stray advances after the sixteenth key are sent to catch a counter that wraps into a new sequence. A load that coincides with an advance checks that the restart is not skipped or shifted by one step. Flipping the mode input mid-sequence catches an unlatched direction. Flipping only the parity bits catches a permuted choice that picks up a wrong key bit.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
    localparam int KEY_W  = 64;
    localparam int HALF_W = 28;
    localparam int CD_W   = 2 * HALF_W;
    localparam int RK_W   = 48;
    localparam int ROUNDS = 16;
    localparam int STEP_W = $clog2(ROUNDS);

    // Source bit (1 = most significant key bit) for each of the 56 kept bits.
    localparam int KEEP_MAP [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // Source bit (1 = most significant bit of C|D) for each round-key bit.
    localparam int PICK_MAP [RK_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    typedef struct packed {
        logic [CD_W-1:0]   cd;
        logic [STEP_W-1:0] step;
        logic              live;
        logic              rev;
    } ks_state_t;

    // Forward rotate amount before round r (0-based).
    function automatic logic [1:0] fwd_amount(input int unsigned r);
        return (r == 0 || r == 1 || r == 8 || r == ROUNDS - 1) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/des_keep_select.sv
module des_keep_select
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output logic [CD_W-1:0]  cd
);
    for (genvar j = 0; j < CD_W; j++) begin : g_keep
        assign cd[CD_W-1-j] = key[KEY_W - KEEP_MAP[j]];
    end
endmodule

// File: rtl/des_pick_select.sv
module des_pick_select
    import des_ks_pkg::*;
(
    input  logic [CD_W-1:0] cd,
    output logic [RK_W-1:0] rk
);
    for (genvar j = 0; j < RK_W; j++) begin : g_pick
        assign rk[RK_W-1-j] = cd[CD_W - PICK_MAP[j]];
    end
endmodule

// File: rtl/des_half_rotator.sv
module des_half_rotator #(
    parameter int W = 28
) (
    input  logic [W-1:0] din,
    input  logic [1:0]   amount,
    input  logic         to_right,
    output logic [W-1:0] dout
);
    logic [W-1:0] by1, by2;

    always_comb begin
        if (to_right) begin
            by1 = {din[0], din[W-1:1]};
            by2 = {din[1:0], din[W-1:2]};
        end else begin
            by1 = {din[W-2:0], din[W-1]};
            by2 = {din[W-3:0], din[W-1:W-2]};
        end
        unique case (amount)
            2'd1:    dout = by1;
            2'd2:    dout = by2;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/des_key_sequencer.sv
module des_key_sequencer
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              decrypt,
    input  logic              advance,
    output logic [RK_W-1:0]   round_key,
    output logic [STEP_W-1:0] round_idx,
    output logic              key_valid
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ROUNDS - 1);

    ks_state_t s_q, s_d;

    logic [CD_W-1:0]   kept_cd;
    logic [CD_W-1:0]   rot_src, rot_out;
    logic [1:0]        rot_amt;
    logic              rot_right;
    logic [STEP_W-1:0] next_step;

    des_keep_select u_keep (.key(key_in), .cd(kept_cd));

    assign next_step = s_q.step + 1'b1;

    always_comb begin
        if (load) begin
            rot_src   = kept_cd;
            rot_right = 1'b0;
            rot_amt   = decrypt ? 2'd0 : fwd_amount(0);
        end else begin
            rot_src   = s_q.cd;
            rot_right = s_q.rev;
            rot_amt   = s_q.rev ? fwd_amount(ROUNDS - int'(next_step))
                                : fwd_amount(int'(next_step));
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        des_half_rotator #(.W(HALF_W)) u_rot (
            .din      (rot_src[h*HALF_W +: HALF_W]),
            .amount   (rot_amt),
            .to_right (rot_right),
            .dout     (rot_out[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cd   = rot_out;
            s_d.step = '0;
            s_d.live = 1'b1;
            s_d.rev  = decrypt;
        end else if (advance && s_q.live) begin
            if (s_q.step == LAST_STEP) begin
                s_d.live = 1'b0;
            end else begin
                s_d.cd   = rot_out;
                s_d.step = next_step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    des_pick_select u_pick (.cd(s_q.cd), .rk(round_key));

    assign round_idx = s_q.rev ? (LAST_STEP - s_q.step) : s_q.step;
    assign key_valid = s_q.live;

    // R2 R5 R8
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> key_valid && (round_idx == ($past(decrypt) ? LAST_STEP : '0)));

    // R4 R5
    step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && key_valid && round_idx != (s_q.rev ? '0 : LAST_STEP))
        |=> key_valid && (round_idx != $past(round_idx)));

    // R6
    sixteen_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && key_valid && s_q.step == LAST_STEP) |=> !key_valid);

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !load) |=> !key_valid && $stable(round_key) && $stable(round_idx));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(round_key) && $stable(key_valid));

    // R3
    weight_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> $countones(s_q.cd) == $past($countones(s_q.cd)));
endmodule

// File: tb/des_key_sequencer_bench.sv
module des_key_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [63:0] key_in = '0;
    logic        decrypt = 1'b0;
    logic        advance = 1'b0;
    logic [47:0] round_key;
    logic [3:0]  round_idx;
    logic        key_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] TEST_KEY = 64'h133457799BBCDFF1;
    localparam logic [63:0] PAR_MASK = 64'h0101010101010101;

    always #10 clk = ~clk;

    des_key_sequencer u_des_key_sequencer (
        .clk(clk), .rst_n(rst_n), .load(load), .key_in(key_in),
        .decrypt(decrypt), .advance(advance), .round_key(round_key),
        .round_idx(round_idx), .key_valid(key_valid)
    );

    function automatic logic [47:0] ref_key(input int r);
        case (r)
            1:  return 48'h1B02EFFC7072;
            2:  return 48'h79AED9DBC9E5;
            3:  return 48'h55FC8A42CF99;
            4:  return 48'h72ADD6DB351D;
            5:  return 48'h7CEC07EB53A8;
            6:  return 48'h63A53E507B2F;
            7:  return 48'hEC84B7F618BC;
            8:  return 48'hF78A3AC13BFB;
            9:  return 48'hE0DBEBEDE781;
            10: return 48'hB1F347BA464F;
            11: return 48'h215FD3DED386;
            12: return 48'h7571F59467E9;
            13: return 48'h97C5D1FABA41;
            14: return 48'h5F43B7F2E73A;
            15: return 48'hBF918D3D3F0A;
            default: return 48'hCB3D8B0E17F5;
        endcase
    endfunction

    task automatic expect_out(input string req, input logic [47:0] k,
                              input logic [3:0] idx, input logic v);
        checks++;
        if (round_key !== k || round_idx !== idx || key_valid !== v) begin
            errors++;
            $display("FAIL %s: key=%h idx=%0d valid=%b expected key=%h idx=%0d valid=%b",
                     req, round_key, round_idx, key_valid, k, idx, v);
        end
    endtask

    task automatic expect_valid(input string req, input logic v);
        checks++;
        if (key_valid !== v) begin
            errors++;
            $display("FAIL %s: valid=%b expected %b", req, key_valid, v);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_load(input logic [63:0] k, input logic dec, input logic adv);
        load = 1'b1; key_in = k; decrypt = dec; advance = adv;
        @(negedge clk);
        load = 1'b0; advance = 1'b0;
    endtask

    task automatic do_step();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1", '0, 4'd0, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", '0, 4'd0, 1'b0);
    endtask

    task automatic t_forward();
        do_load(TEST_KEY, 1'b0, 1'b0);
        expect_out("R2", ref_key(1), 4'd0, 1'b1);
        for (int r = 2; r <= 16; r++) begin
            do_step();
            expect_out("R3 R4 R6", ref_key(r), 4'(r - 1), 1'b1);
        end
        do_step();
        expect_out("R6", ref_key(16), 4'd15, 1'b0);
    endtask

    task automatic t_idle_advance();
        do_step();
        do_step();
        expect_out("R7", ref_key(16), 4'd15, 1'b0);
    endtask

    task automatic t_reverse();
        do_load(TEST_KEY, 1'b1, 1'b0);
        expect_out("R5", ref_key(16), 4'd15, 1'b1);
        for (int r = 15; r >= 1; r--) begin
            do_step();
            expect_out("R5 R3", ref_key(r), 4'(r - 1), 1'b1);
        end
        do_step();
        expect_valid("R6", 1'b0);
    endtask

    task automatic t_hold_and_mode();
        do_load(TEST_KEY, 1'b0, 1'b0);
        repeat (3) do_step();
        repeat (5) @(negedge clk);
        expect_out("R9", ref_key(4), 4'd3, 1'b1);
        decrypt = 1'b1;
        do_step();
        expect_out("R10", ref_key(5), 4'd4, 1'b1);
        decrypt = 1'b0;
    endtask

    task automatic t_reload_priority();
        do_load(TEST_KEY, 1'b0, 1'b1);
        expect_out("R8", ref_key(1), 4'd0, 1'b1);
        do_step();
        expect_out("R8", ref_key(2), 4'd1, 1'b1);
        repeat (4) do_step();
        do_load(TEST_KEY, 1'b1, 1'b1);
        expect_out("R8", ref_key(16), 4'd15, 1'b1);
    endtask

    task automatic t_parity();
        do_load(TEST_KEY ^ PAR_MASK, 1'b0, 1'b0);
        expect_out("R11", ref_key(1), 4'd0, 1'b1);
        repeat (8) do_step();
        expect_out("R11", ref_key(9), 4'd8, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_idle_advance();
        t_reverse();
        t_hold_and_mode();
        t_reload_priority();
        t_parity();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule